// File: doc/BRIEF.md
# Multi-Standard Audio Serial Transmitter

This block is the transmit side of a stereo audio serial port. It turns a stream of parallel audio samples into one serial data line, and it drives the word-select line and the bit clock that go with that data line. An external prescaler sets the bit rate through a single-cycle tick: every tick moves the bit clock by one half period. Static configuration inputs choose the framing standard, the data and slot widths and the idle level of the bit clock. These inputs are changed only while the block is disabled.

Samples arrive over a valid/ready handshake. The first sample after enable goes to the left channel, and later samples alternate between right and left. The transmitter takes one sample at the start of every slot. If no sample is offered at that moment, it sends zeros for the slot and sets a sticky underrun flag. Dropping `enable` stops the port and returns every output to idle. Raising `enable` again starts a fresh frame at the first bit of the left slot.

Top module: `aud_serial_tx`

## Requirements
- R1: When `enable` is low, `bclkOut` sits at its idle level (equal to `cfgIdleHigh`), and `sdOut`, `wsOut`, `sampleReady` and `underrun` are all 0 from the next clock on.
- R2: While enabled, each `tick` moves the bit clock one half period, so a tick on every second cycle gives a bit period of 4 cycles. `sdOut` and `wsOut` change only as the clock returns to its idle level. They are stable when it leaves idle, which is the edge on which a receiver samples.
- R3: `cfgFmt` selects the data width within the slot width: 0 is 16 in 16, 1 is 16 in 32, 2 is 24 in 32 and 3 is 32 in 32. A frame is two slots, left first and then right.
- R4: Data goes out MSB first. Except in LSB-justified mode, the data fills the first bits of its slot, and the bits left over after the data are 0.
- R5: In LSB-justified mode (`cfgStd`=2), the data LSB falls on the last bit of the slot, and the bits before the data MSB are 0.
- R6: In Philips mode (`cfgStd`=0), `wsOut` is 0 for the left slot and 1 for the right slot. It changes one bit period before the MSB of each slot, so the data runs one bit behind the word-select edge.
- R7: In MSB-justified mode (`cfgStd`=1) and in LSB-justified mode, `wsOut` is 0 for left and 1 for right. It changes on the first bit of each slot.
- R8: In PCM mode (`cfgStd`=3) with `cfgLongSync`=0, `wsOut` is a single-bit pulse on the bit that comes just before the frame's first data bit. The data runs one bit late, and `wsOut` is 0 at every other time.
- R9: In PCM mode with `cfgLongSync`=1, `wsOut` is 1 for the first 13 bits of each frame and 0 for the remaining bits. The data MSB lines up with the rising sync. `cfgLongSync` has no effect outside PCM mode.
- R10: `sampleReady` pulses for one cycle at each slot start, and the sample is taken when `sampleValid` is high in that cycle. By the time bit g is sampled, g/S+1 slots have started, where S is the slot width.
- R11: If `sampleValid` is low at a slot start, that slot carries all zeros and `underrun` goes to 1. It stays at 1 until `enable` is low.
- R12: Re-enabling after a disable always restarts at bit 0 of a left slot.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | Runs the port when high; clears it when low |
| tick | input | 1 | Half-bit-period strobe from the prescaler |
| cfgStd | input | 2 | Framing standard: 0 Philips, 1 MSB-justified, 2 LSB-justified, 3 PCM |
| cfgLongSync | input | 1 | PCM sync length: 1 long, 0 short |
| cfgFmt | input | 2 | Data width within slot width (see R3) |
| cfgIdleHigh | input | 1 | Bit-clock idle level |
| sampleData | input | 32 | Right-aligned audio sample |
| sampleValid | input | 1 | Sample offered |
| sampleReady | output | 1 | Sample taken this cycle |
| sdOut | output | 1 | Serial data |
| wsOut | output | 1 | Word select / frame sync |
| bclkOut | output | 1 | Bit clock |
| underrun | output | 1 | Sticky missed-sample flag |

## Verification
The assertions rely on three assumptions about the inputs: the configuration does not change while `enable` is high, `tick` never arrives in two back-to-back cycles, and `sampleData` and `sampleValid` stay steady across the cycle in which `sampleReady` is high. The stimulus meets all three. It changes the configuration only while the block is disabled, toggles `tick` every cycle so that a tick comes every second cycle, and updates the sample and valid inputs on the falling clock edge, away from the edge at which a sample is taken. The bench sweeps every standard, every format and both clock polarities, and runs one extra pass with no samples offered.

// File: rtl/aud_tx_pkg.sv
package aud_tx_pkg;
  localparam int MAX_SLOT = 32;
  localparam int SHORT_SLOT = 16;
  localparam int CNT_W = $clog2(2 * MAX_SLOT);

  typedef enum logic [1:0] {
    STD_PHILIPS = 2'd0,
    STD_MSBJ    = 2'd1,
    STD_LSBJ    = 2'd2,
    STD_PCM     = 2'd3
  } frameStd_e;

  typedef enum logic [1:0] {
    FMT_16IN16 = 2'd0,
    FMT_16IN32 = 2'd1,
    FMT_24IN32 = 2'd2,
    FMT_32IN32 = 2'd3
  } slotFmt_e;

  typedef struct packed {
    logic             active;
    logic             shift;
    logic             slotStart;
    logic             chan;
    logic [CNT_W-1:0] bitNum;
  } txStrobe_t;
endpackage

// File: rtl/aud_tx_ctrl.sv
module aud_tx_ctrl
  import aud_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       enable,
  input  logic       tick,
  input  logic [1:0] cfgFmt,
  output logic       bitClk,
  output txStrobe_t  strb
);
  logic running;
  logic phase;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] slotLen;
  logic [CNT_W-1:0] lastBit;
  logic [CNT_W-1:0] nextBit;
  logic [CNT_W-1:0] emitBit;

  always_comb begin
    slotLen = (slotFmt_e'(cfgFmt) == FMT_16IN16) ? CNT_W'(SHORT_SLOT) : CNT_W'(MAX_SLOT);
    lastBit = CNT_W'((slotLen << 1) - 1'b1);
    nextBit = (bitCnt == lastBit) ? '0 : bitCnt + 1'b1;
    emitBit = running ? nextBit : '0;
    strb.active    = enable;
    strb.shift     = enable & (~running | (tick & phase));
    strb.bitNum    = emitBit;
    strb.slotStart = (emitBit & (slotLen - 1'b1)) == '0;
    strb.chan      = emitBit >= slotLen;
  end

  assign bitClk = phase;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      running <= 1'b0;
      phase   <= 1'b0;
      bitCnt  <= '0;
    end else if (!enable) begin
      running <= 1'b0;
      phase   <= 1'b0;
      bitCnt  <= '0;
    end else if (!running) begin
      running <= 1'b1;
      bitCnt  <= '0;
    end else if (tick) begin
      phase <= ~phase;
      if (phase) bitCnt <= nextBit;
    end
  end

  // R2
  phase_tick_chk: assert property (@(posedge clk) disable iff (!rstN)
    (running && enable && !tick) |=> $stable(phase));

  // R3
  bitcnt_range_chk: assert property (@(posedge clk) disable iff (!rstN)
    running |-> (bitCnt <= lastBit));

  // R12
  start_left_chk: assert property (@(posedge clk) disable iff (!rstN)
    (enable && !running) |-> (strb.shift && strb.slotStart && !strb.chan));
endmodule

// File: rtl/aud_tx_dpath.sv
module aud_tx_dpath
  import aud_tx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LONG_SYNC = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  txStrobe_t         strb,
  input  logic [1:0]        cfgStd,
  input  logic              cfgLongSync,
  input  logic [1:0]        cfgFmt,
  input  logic [WORD_W-1:0] sampleData,
  input  logic              sampleValid,
  output logic              sampleReady,
  output logic              sdOut,
  output logic              wsOut,
  output logic              underrun
);
  localparam int PAD16 = WORD_W - 16;
  localparam int PAD24 = WORD_W - 24;

  logic [WORD_W-1:0] shreg;
  logic [WORD_W-1:0] word;
  logic [WORD_W-1:0] fresh;
  logic delayBit;
  logic alignedBit;
  logic lsbJust;
  logic isPcm;
  logic useDelay;
  logic wsNext;
  logic take;

  always_comb begin
    lsbJust = frameStd_e'(cfgStd) == STD_LSBJ;
    isPcm   = frameStd_e'(cfgStd) == STD_PCM;
    unique case (slotFmt_e'(cfgFmt))
      FMT_16IN16: word = {sampleData[15:0], {PAD16{1'b0}}};
      FMT_16IN32: word = lsbJust ? {{PAD16{1'b0}}, sampleData[15:0]}
                                 : {sampleData[15:0], {PAD16{1'b0}}};
      FMT_24IN32: word = lsbJust ? {{PAD24{1'b0}}, sampleData[23:0]}
                                 : {sampleData[23:0], {PAD24{1'b0}}};
      default:    word = sampleData;
    endcase
    take       = strb.shift & strb.slotStart;
    fresh      = sampleValid ? word : '0;
    alignedBit = strb.slotStart ? fresh[WORD_W-1] : shreg[WORD_W-1];
    useDelay   = (frameStd_e'(cfgStd) == STD_PHILIPS) | (isPcm & ~cfgLongSync);
    if (isPcm)
      wsNext = cfgLongSync ? (strb.bitNum < CNT_W'(LONG_SYNC)) : (strb.bitNum == '0);
    else
      wsNext = strb.chan;
  end

  assign sampleReady = take;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shreg    <= '0;
      delayBit <= 1'b0;
      sdOut    <= 1'b0;
      wsOut    <= 1'b0;
      underrun <= 1'b0;
    end else if (!strb.active) begin
      shreg    <= '0;
      delayBit <= 1'b0;
      sdOut    <= 1'b0;
      wsOut    <= 1'b0;
      underrun <= 1'b0;
    end else if (strb.shift) begin
      shreg    <= strb.slotStart ? (fresh << 1) : (shreg << 1);
      delayBit <= alignedBit;
      sdOut    <= useDelay ? delayBit : alignedBit;
      wsOut    <= wsNext;
      if (take && !sampleValid) underrun <= 1'b1;
    end
  end

  // R1
  idle_chk: assert property (@(posedge clk) disable iff (!rstN)
    !strb.active |=> (!sdOut && !wsOut && !underrun));

  // R11
  underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (underrun && strb.active) |=> underrun);

  // R11
  underrun_set_chk: assert property (@(posedge clk) disable iff (!rstN)
    (sampleReady && !sampleValid) |=> underrun);

  // R10
  ready_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    sampleReady |=> !sampleReady);

  // R2
  sd_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.active && !strb.shift) |=> ($stable(sdOut) && $stable(wsOut)));
endmodule

// File: rtl/aud_serial_tx.sv
module aud_serial_tx
  import aud_tx_pkg::*;
#(
  parameter int WORD_W = 32,
  parameter int LONG_SYNC = 13
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              enable,
  input  logic              tick,
  input  logic [1:0]        cfgStd,
  input  logic              cfgLongSync,
  input  logic [1:0]        cfgFmt,
  input  logic              cfgIdleHigh,
  input  logic [WORD_W-1:0] sampleData,
  input  logic              sampleValid,
  output logic              sampleReady,
  output logic              sdOut,
  output logic              wsOut,
  output logic              bclkOut,
  output logic              underrun
);
  txStrobe_t strb;
  logic bitClk;

  aud_tx_ctrl u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .enable (enable),
    .tick   (tick),
    .cfgFmt (cfgFmt),
    .bitClk (bitClk),
    .strb   (strb)
  );

  aud_tx_dpath #(.WORD_W(WORD_W), .LONG_SYNC(LONG_SYNC)) u_dpath (
    .clk         (clk),
    .rstN        (rstN),
    .strb        (strb),
    .cfgStd      (cfgStd),
    .cfgLongSync (cfgLongSync),
    .cfgFmt      (cfgFmt),
    .sampleData  (sampleData),
    .sampleValid (sampleValid),
    .sampleReady (sampleReady),
    .sdOut       (sdOut),
    .wsOut       (wsOut),
    .underrun    (underrun)
  );

  assign bclkOut = bitClk ^ cfgIdleHigh;
endmodule

// File: tb/sim_aud_serial_tx.sv
module sim_aud_serial_tx;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic enable = 1'b0;
  logic tick = 1'b0;
  logic [1:0] cfgStd = 2'd0;
  logic cfgLongSync = 1'b0;
  logic [1:0] cfgFmt = 2'd0;
  logic cfgIdleHigh = 1'b0;
  logic [31:0] sampleData = '0;
  logic sampleValid = 1'b0;
  logic sampleReady, sdOut, wsOut, bclkOut, underrun;
  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  aud_serial_tx u0 (
    .clk(clk), .rstN(rstN), .enable(enable), .tick(tick),
    .cfgStd(cfgStd), .cfgLongSync(cfgLongSync), .cfgFmt(cfgFmt),
    .cfgIdleHigh(cfgIdleHigh), .sampleData(sampleData),
    .sampleValid(sampleValid), .sampleReady(sampleReady),
    .sdOut(sdOut), .wsOut(wsOut), .bclkOut(bclkOut), .underrun(underrun)
  );

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] pat(input int k);
    return (32'h9E3779B9 * (k + 3)) ^ 32'h5A5A1234;
  endfunction

  function automatic int slotOf(input int fmt);
    return (fmt == 0) ? 16 : 32;
  endfunction

  // aligned data bit g: MSB first, zero padding (R4), LSB-justified (R5)
  function automatic bit aBit(input int fmt, input int std, input bit noData, input int g);
    int s, dl, k, p, idx;
    logic [31:0] w;
    s = slotOf(fmt);
    dl = (fmt <= 1) ? 16 : ((fmt == 2) ? 24 : 32);
    k = g / s;
    p = g % s;
    idx = (std == 2) ? (s - 1 - p) : (dl - 1 - p);
    w = pat(k);
    if (noData || idx < 0 || idx >= dl) return 1'b0;
    return w[idx];
  endfunction

  function automatic bit expSd(input int fmt, input int std, input bit longS, input bit noData, input int g);
    bit dly;
    dly = (std == 0) || (std == 3 && !longS);
    if (dly) return (g == 0) ? 1'b0 : aBit(fmt, std, noData, g - 1);
    return aBit(fmt, std, noData, g);
  endfunction

  function automatic bit expWs(input int fmt, input int std, input bit longS, input int g);
    int s, b;
    s = slotOf(fmt);
    b = g % (2 * s);
    if (std == 3) return longS ? (b < 13) : (b == 0);
    return b >= s;
  endfunction

  task automatic runCfg(input int std, input bit longS, input int fmt, input bit idle,
                        input bit valid, input int nBits);
    int g, k, readyCnt, cyc, lastEdge, s;
    bit prevInt, curInt;
    string wsTag, sdTag;
    s = slotOf(fmt);
    wsTag = (std == 0) ? "R6" : ((std == 3) ? (longS ? "R9" : "R8") : "R7");
    sdTag = (std == 2) ? "R5" : "R4";
    @(negedge clk);
    enable = 1'b0;
    cfgStd = 2'(std);
    cfgLongSync = longS;
    cfgFmt = 2'(fmt);
    cfgIdleHigh = idle;
    sampleValid = valid;
    repeat (3) @(negedge clk);
    // R1: disabled outputs idle
    chk(bclkOut == idle && !sdOut && !wsOut && !underrun && !sampleReady, "R1",
        {bclkOut, sdOut, wsOut, underrun, sampleReady}, {idle, 4'b0});
    g = 0; k = 0; readyCnt = 0; cyc = 0; lastEdge = -1; prevInt = 1'b0;
    enable = 1'b1;
    sampleData = pat(0);
    #1;
    if (sampleReady) begin readyCnt++; if (sampleValid) k++; end
    while (g < nBits) begin
      @(negedge clk);
      cyc++;
      curInt = bclkOut ^ idle;
      if (curInt && !prevInt) begin
        chk(sdOut == expSd(fmt, std, longS, !valid, g), sdTag, sdOut,
            expSd(fmt, std, longS, !valid, g));
        chk(wsOut == expWs(fmt, std, longS, g), wsTag, wsOut, expWs(fmt, std, longS, g));
        if (g == 0)
          chk(wsOut == expWs(fmt, std, longS, 0) && sdOut == expSd(fmt, std, longS, !valid, 0),
              "R12", {wsOut, sdOut}, {expWs(fmt, std, longS, 0), expSd(fmt, std, longS, !valid, 0)});
        chk(readyCnt == g / s + 1, "R3 R10", readyCnt, g / s + 1);
        if (valid) chk(k == readyCnt, "R10", k, readyCnt);
        if (lastEdge >= 0) chk(cyc - lastEdge == 4, "R2", cyc - lastEdge, 4);
        lastEdge = cyc;
        g++;
      end
      prevInt = curInt;
      tick = ~tick;
      sampleData = pat(k);
      #1;
      if (sampleReady) begin readyCnt++; if (sampleValid) k++; end
    end
    if (!valid) chk(underrun == 1'b1, "R11", underrun, 1);
    else chk(underrun == 1'b0, "R11", underrun, 0);
    @(negedge clk);
    enable = 1'b0;
    @(negedge clk);
    chk(!underrun && !sdOut && !wsOut && bclkOut == idle, "R11 R1",
        {underrun, sdOut, wsOut, bclkOut}, {3'b0, idle});
  endtask

  initial begin
    #(8 * 190000);
    errors++;
    $display("FAIL watchdog actual hung expected done");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(bclkOut == 1'b0 && !sdOut && !wsOut && !sampleReady && !underrun, "R1",
        {bclkOut, sdOut, wsOut, sampleReady, underrun}, 0);
    rstN = 1'b1;
    for (int st = 0; st < 5; st++)
      for (int fm = 0; fm < 4; fm++)
        for (int id = 0; id < 2; id++)
          runCfg((st < 4) ? st : 3, st == 4, fm, id[0], 1'b1, 4 * slotOf(fm));
    // R9: long-sync select ignored outside PCM
    runCfg(1, 1'b1, 2, 1'b0, 1'b1, 128);
    // R11: no samples offered
    runCfg(0, 1'b0, 0, 1'b0, 1'b0, 64);
    runCfg(2, 1'b0, 1, 1'b1, 1'b0, 64);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule